// File: doc/BRIEF.md
# Audio Serial Port Control and Status Register Bank

This block is the software-visible register bank of an audio serial port. It holds a 32-bit control word that drives the serial datapath: soft reset, clock gating, bit-clock rate selection, interrupt enables, frame and bit formatting, word length, direction and run. It also holds a status word. The status word mixes live indications from the datapath with two sticky FIFO error flags, one for underflow and one for overflow. The block raises a single error interrupt from those flags.

Each register sits in its own 16-byte group. Within a group, offset 0 is the plain register. Offset 4 is a set alias that ORs the written ones into the register. Offset 8 is a clear alias that clears the written ones. Software can therefore flip single bits without a read-modify-write race against hardware events. All three offsets read back the current value.

The bus is a single-cycle port. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are high. Read data is combinational from the current register state.

Top module: `aud_csr_bank`

## Requirements
- R1: After `rst_n` is released, the control word is 0x4000_0000 (clock-gate bit 30 set, all other bits clear), both sticky flags are clear and `err_irq` is 0.
- R2: A write to the control base address (0x00) loads the word except reserved bits 23:21, which always read 0. The set alias (0x04) and clear alias (0x08) read back the same value as 0x00.
- R3: A write to the control set alias (0x04) ORs the written ones into the control word and leaves every other bit unchanged.
- R4: A write to the control clear alias (0x08) clears exactly the bits written as one and leaves every other bit unchanged.
- R5: Whenever control bit 31 (soft reset) becomes 1, the other 31 control bits become 0, and writes cannot set them while bit 31 stays 1. One cycle after bit 31 is seen set, both sticky flags are 0, and FIFO error events are ignored while it stays set. Clearing bit 31 through the clear alias releases the soft reset.
- R6: The status word (group 0x10) keeps underflow in bit 6 and overflow in bit 5. Either flag is set by a one-cycle pulse on its event input and stays set until software clears it with a one at the status clear alias (0x18). An event in the same cycle as the clear leaves the flag set. A base write (0x10) loads the flags and the set alias (0x14) sets them.
- R7: Status bit 31 always reads 1, and bits 16, 4 and 0 read the live `dma_req`, `fifo_service` and `port_busy` inputs. Writes have no effect on these bits, and all other status bits read 0.
- R8: `err_irq` is 1 exactly when (underflow OR overflow) AND control bit 25 (error interrupt enable).
- R9: The version group (0x30, 0x34, 0x38) reads the constant {major[31:24], minor[23:16], step[15:0]}, 0x0102_0003 by default. Writes to it are ignored.
- R10: Any address whose group is not 0x0, 0x1 or 0x3 (the data group 0x20 included) reads 0, and writes to it change nothing. The same holds for any in-group offset other than 0, 4 or 8.
- R11: When `bus_sel` is low, no register changes whatever `bus_wr`, `bus_addr` and `bus_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address: group in bits 7:4, offset in bits 3:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational; 0 when not selected |
| evt_underflow | input | 1 | One-cycle FIFO underflow event |
| evt_overflow | input | 1 | One-cycle FIFO overflow event |
| fifo_service | input | 1 | Live FIFO service request |
| dma_req | input | 1 | Live DMA request |
| port_busy | input | 1 | Live datapath busy |
| ctrl_word | output | 32 | Current control word to the datapath |
| err_irq | output | 1 | FIFO error interrupt |

## Verification
Several rules are checked by assertions on every cycle. The soft-reset hold on the control word, the set and clear alias effects, the stickiness of the error flags and their setting by events are checked this way. So are the interrupt depending on its enable, the version word being constant, and a decode never reaching two registers at once. Other behaviour shows only in the bench's scenarios. That includes the exact reset image, the masked reserved bits, the live status bits that ignore writes and the zero reads of unmapped addresses. It also includes the ordering when a clear and an event meet in one cycle, and the release of soft reset through the clear alias. A long random mix of accesses and events, compared against a bench model, covers the same behaviour again.

// File: rtl/aud_csr_pkg.sv
package aud_csr_pkg;

    typedef enum logic [1:0] {
        WOP_NONE = 2'd0,
        WOP_LOAD = 2'd1,
        WOP_SET  = 2'd2,
        WOP_CLR  = 2'd3
    } wop_e;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_CTRL = 2'd1,
        RSEL_STAT = 2'd2,
        RSEL_VER  = 2'd3
    } rsel_e;

    localparam int GRP_CTRL = 0;
    localparam int GRP_STAT = 1;
    localparam int GRP_VER  = 3;

    localparam logic [3:0] OFF_BASE = 4'h0;
    localparam logic [3:0] OFF_SET  = 4'h4;
    localparam logic [3:0] OFF_CLR  = 4'h8;

    localparam int CB_SRST   = 31;
    localparam int CB_ERR_IE = 25;

    localparam int SB_PRESENT = 31;
    localparam int SB_DMA     = 16;
    localparam int SB_UNDER   = 6;
    localparam int SB_OVER    = 5;
    localparam int SB_SVC     = 4;
    localparam int SB_BUSY    = 0;

    localparam logic [31:0] CTRL_WMASK = 32'hFF1F_FFFF;
    localparam logic [31:0] CTRL_RST   = 32'h4000_0000;
    localparam logic [31:0] SRST_IMAGE = 32'h8000_0000;
    localparam logic [31:0] STAT_WMASK = 32'h0000_0060;

    function automatic logic [31:0] apply_op(wop_e op, logic [31:0] cur,
                                             logic [31:0] wd, logic [31:0] mask);
        logic [31:0] r;
        case (op)
            WOP_LOAD: r = wd & mask;
            WOP_SET:  r = cur | (wd & mask);
            WOP_CLR:  r = cur & ~(wd & mask);
            default:  r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aud_csr_decode.sv
module aud_csr_decode
    import aud_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output wop_e              ctrl_op,
    output wop_e              stat_op,
    output rsel_e             rsel
);
    localparam int GRP_W = ADDR_W - 4;

    logic [GRP_W-1:0] grp;
    logic [3:0]       off;
    logic             off_ok;
    wop_e             kind;

    always_comb begin
        grp    = addr[ADDR_W-1:4];
        off    = addr[3:0];
        off_ok = (off == OFF_BASE) || (off == OFF_SET) || (off == OFF_CLR);
        case (off)
            OFF_BASE: kind = WOP_LOAD;
            OFF_SET:  kind = WOP_SET;
            OFF_CLR:  kind = WOP_CLR;
            default:  kind = WOP_NONE;
        endcase

        ctrl_op = WOP_NONE;
        stat_op = WOP_NONE;
        rsel    = RSEL_NONE;
        if (sel && off_ok) begin
            if (grp == GRP_W'(GRP_CTRL)) begin
                rsel = RSEL_CTRL;
                if (wr) ctrl_op = kind;
            end else if (grp == GRP_W'(GRP_STAT)) begin
                rsel = RSEL_STAT;
                if (wr) stat_op = kind;
            end else if (grp == GRP_W'(GRP_VER)) begin
                rsel = RSEL_VER;
            end
        end
    end

    // R10: one access never reaches two registers
    p_single_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_op != WOP_NONE, stat_op != WOP_NONE}));

    // R11: no write strobe without a selected write
    p_no_strobe_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr) |-> (ctrl_op == WOP_NONE && stat_op == WOP_NONE));

endmodule

// File: rtl/aud_csr_ctrl_reg.sv
module aud_csr_ctrl_reg
    import aud_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  wop_e        op,
    input  logic [31:0] wdata,
    output logic [31:0] ctrl_q
);
    typedef struct packed {
        logic [31:0] word;
    } ctrl_s;

    ctrl_s st_d, st_q;

    always_comb begin
        st_d.word = apply_op(op, st_q.word, wdata, CTRL_WMASK);
        if (st_d.word[CB_SRST]) st_d.word = SRST_IMAGE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.word <= CTRL_RST;
        else        st_q      <= st_d;
    end

    assign ctrl_q = st_q.word;

    // R5: soft reset holds every other control bit at zero
    p_srst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.word[CB_SRST] |-> (st_q.word[30:0] == 31'd0));

    // R3: set alias ORs the written ones in
    p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == WOP_SET && !wdata[CB_SRST] && !st_q.word[CB_SRST])
        |=> st_q.word == ($past(st_q.word) | $past(wdata & CTRL_WMASK)));

    // R4: clear alias drops only the written ones
    p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == WOP_CLR && !st_q.word[CB_SRST])
        |=> ((st_q.word & $past(wdata & CTRL_WMASK)) == 32'd0) &&
            ((st_q.word | $past(wdata & CTRL_WMASK)) ==
             ($past(st_q.word) | $past(wdata & CTRL_WMASK))));

    // R11: no access, no change
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op == WOP_NONE) |=> $stable(st_q.word));

endmodule

// File: rtl/aud_csr_stat_reg.sv
module aud_csr_stat_reg
    import aud_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  wop_e        op,
    input  logic [31:0] wdata,
    input  logic        srst,
    input  logic        evt_uf,
    input  logic        evt_ov,
    output logic        uf_q,
    output logic        ov_q
);
    typedef struct packed {
        logic uf;
        logic ov;
    } flags_s;

    flags_s      st_d, st_q;
    logic [31:0] cur_img;
    logic [31:0] nxt_img;

    always_comb begin
        cur_img           = '0;
        cur_img[SB_UNDER] = st_q.uf;
        cur_img[SB_OVER]  = st_q.ov;
        nxt_img           = apply_op(op, cur_img, wdata, STAT_WMASK);
        st_d.uf           = nxt_img[SB_UNDER] | evt_uf;
        st_d.ov           = nxt_img[SB_OVER]  | evt_ov;
        if (srst) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign uf_q = st_q.uf;
    assign ov_q = st_q.ov;

    // R6: a flag stays set without an explicit status write
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.uf && !srst && op == WOP_NONE) |=> st_q.uf);

    // R6: an event always lands, even against a clear
    p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ov && !srst) |=> st_q.ov);

    // R5: soft reset wipes both flags
    p_srst_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!st_q.uf && !st_q.ov));

endmodule

// File: rtl/aud_csr_bank.sv
module aud_csr_bank
    import aud_csr_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  VER_MAJOR = 8'h01,
    parameter logic [7:0]  VER_MINOR = 8'h02,
    parameter logic [15:0] VER_STEP  = 16'h0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              evt_underflow,
    input  logic              evt_overflow,
    input  logic              fifo_service,
    input  logic              dma_req,
    input  logic              port_busy,
    output logic [31:0]       ctrl_word,
    output logic              err_irq
);
    localparam logic [31:0] VERSION = {VER_MAJOR, VER_MINOR, VER_STEP};
    localparam logic [ADDR_W-1:0] VER_ADDR = ADDR_W'(GRP_VER * 16);

    wop_e        ctrl_op, stat_op;
    rsel_e       rsel;
    logic [31:0] ctrl_q;
    logic        uf_q, ov_q;
    logic [31:0] stat_word;

    aud_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .ctrl_op (ctrl_op),
        .stat_op (stat_op),
        .rsel    (rsel)
    );

    aud_csr_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (ctrl_op),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_q)
    );

    aud_csr_stat_reg u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (stat_op),
        .wdata  (bus_wdata),
        .srst   (ctrl_q[CB_SRST]),
        .evt_uf (evt_underflow),
        .evt_ov (evt_overflow),
        .uf_q   (uf_q),
        .ov_q   (ov_q)
    );

    always_comb begin
        stat_word             = '0;
        stat_word[SB_PRESENT] = 1'b1;
        stat_word[SB_DMA]     = dma_req;
        stat_word[SB_UNDER]   = uf_q;
        stat_word[SB_OVER]    = ov_q;
        stat_word[SB_SVC]     = fifo_service;
        stat_word[SB_BUSY]    = port_busy;

        case (rsel)
            RSEL_CTRL: bus_rdata = ctrl_q;
            RSEL_STAT: bus_rdata = stat_word;
            RSEL_VER:  bus_rdata = VERSION;
            default:   bus_rdata = '0;
        endcase
    end

    assign ctrl_word = ctrl_q;
    assign err_irq   = (uf_q | ov_q) & ctrl_q[CB_ERR_IE];

    // R8: the interrupt needs both its enable and a pending flag
    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (ctrl_word[CB_ERR_IE] && (uf_q || ov_q)));

    // R9: the version word never varies
    p_ver_const_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == VER_ADDR) |-> bus_rdata == VERSION);

endmodule

// File: tb/aud_csr_bank_tb.sv
module aud_csr_bank_tb;

    localparam logic [31:0] VER = 32'h0102_0003;
    localparam logic [31:0] WMASK = 32'hFF1F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        evt_underflow = 1'b0;
    logic        evt_overflow = 1'b0;
    logic        fifo_service = 1'b0;
    logic        dma_req = 1'b0;
    logic        port_busy = 1'b0;
    logic [31:0] ctrl_word;
    logic        err_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_ctrl;
    logic        m_uf, m_ov;

    always #2.5 clk = ~clk;

    aud_csr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_underflow(evt_underflow), .evt_overflow(evt_overflow),
        .fifo_service(fifo_service), .dma_req(dma_req), .port_busy(port_busy),
        .ctrl_word(ctrl_word), .err_irq(err_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // 0 none, 1 load, 2 set, 3 clear
    function automatic int opcode(logic [7:0] a, int g);
        if (a[7:4] != g[3:0]) return 0;
        case (a[3:0])
            4'h0: return 1;
            4'h4: return 2;
            4'h8: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] nxt_ctrl(logic [31:0] c, logic we, logic [7:0] a, logic [31:0] d);
        logic [31:0] r;
        int op;
        r = c;
        op = we ? opcode(a, 0) : 0;
        if (op == 1) r = d & WMASK;
        if (op == 2) r = c | (d & WMASK);
        if (op == 3) r = c & ~(d & WMASK);
        if (r[31]) r = 32'h8000_0000;
        return r;
    endfunction

    function automatic logic [1:0] nxt_flags(logic uf, logic ov, logic srst, logic we,
                                             logic [7:0] a, logic [31:0] d, logic eu, logic eo);
        int op;
        logic u, o;
        if (srst) return 2'b00;
        u = uf; o = ov;
        op = we ? opcode(a, 1) : 0;
        if (op == 1) begin u = d[6]; o = d[5]; end
        if (op == 2) begin u = u | d[6]; o = o | d[5]; end
        if (op == 3) begin u = u & ~d[6]; o = o & ~d[5]; end
        return {u | eu, o | eo};
    endfunction

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        logic [31:0] s;
        if (!(a[3:0] == 4'h0 || a[3:0] == 4'h4 || a[3:0] == 4'h8)) return 32'h0;
        s = 32'h8000_0000;
        s[16] = dma_req; s[6] = m_uf; s[5] = m_ov; s[4] = fifo_service; s[0] = port_busy;
        case (a[7:4])
            4'h0: return m_ctrl;
            4'h1: return s;
            4'h3: return VER;
            default: return 32'h0;
        endcase
    endfunction

    task automatic step(input logic s, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input logic eu, input logic eo);
        logic [31:0] nc;
        logic [1:0]  nf;
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        evt_underflow = eu; evt_overflow = eo;
        nc = nxt_ctrl(m_ctrl, s & w, a, d);
        nf = nxt_flags(m_uf, m_ov, m_ctrl[31], s & w, a, d, eu, eo);
        @(posedge clk);
        #1;
        m_ctrl = nc; m_uf = nf[1]; m_ov = nf[0];
        bus_sel = 1'b0; bus_wr = 1'b0; evt_underflow = 1'b0; evt_overflow = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, 1'b1, a, d, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        m_ctrl = 32'h4000_0000; m_uf = 1'b0; m_ov = 1'b0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset image
        @(negedge clk);
        chk("R1 ctrl_word", ctrl_word, 32'h4000_0000);
        chk("R1 err_irq", {31'd0, err_irq}, 32'h0);
        rd(8'h00, v); chk("R1 ctrl read", v, 32'h4000_0000);
        rd(8'h10, v); chk("R1 status read", v, 32'h8000_0000);

        // R2 base load with reserved bits masked, alias reads
        wr(8'h00, 32'h7FFF_FFFF);
        chk("R2 base load", ctrl_word, 32'h7F1F_FFFF);
        rd(8'h04, v); chk("R2 set alias read", v, 32'h7F1F_FFFF);
        rd(8'h08, v); chk("R2 clr alias read", v, 32'h7F1F_FFFF);

        // R4 clear alias
        wr(8'h08, 32'h0000_00F0);
        chk("R4 clear alias", ctrl_word, 32'h7F1F_FF0F);
        wr(8'h00, 32'h0);
        chk("R2 base zero", ctrl_word, 32'h0);

        // R3 set alias
        wr(8'h04, 32'h0200_0001);
        chk("R3 set alias", ctrl_word, 32'h0200_0001);
        wr(8'h04, 32'h0000_0010);
        chk("R3 set alias keeps", ctrl_word, 32'h0200_0011);

        // R6 / R8 sticky underflow with interrupt
        step(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 1'b0);
        rd(8'h10, v); chk("R6 underflow sticky", v, 32'h8000_0040);
        chk("R8 irq on", {31'd0, err_irq}, 32'h1);
        wr(8'h18, 32'h0000_0020);
        rd(8'h10, v); chk("R6 other flag kept", v, 32'h8000_0040);
        step(1'b1, 1'b1, 8'h18, 32'h0000_0040, 1'b1, 1'b0);
        rd(8'h10, v); chk("R6 event beats clear", v, 32'h8000_0040);
        wr(8'h18, 32'h0000_0040);
        rd(8'h10, v); chk("R6 cleared", v, 32'h8000_0000);
        chk("R8 irq off", {31'd0, err_irq}, 32'h0);

        // R8 enable gating
        step(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, 1'b1);
        chk("R8 irq overflow", {31'd0, err_irq}, 32'h1);
        wr(8'h08, 32'h0200_0000);
        chk("R8 irq disabled", {31'd0, err_irq}, 32'h0);
        rd(8'h10, v); chk("R6 overflow kept", v, 32'h8000_0020);
        wr(8'h14, 32'h0000_0040);
        rd(8'h10, v); chk("R6 set alias", v, 32'h8000_0060);
        wr(8'h18, 32'h0000_0060);

        // R7 live bits ignore writes
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R7 live unaffected", v, 32'h8000_0060);
        dma_req = 1'b1; fifo_service = 1'b1; port_busy = 1'b1;
        rd(8'h10, v); chk("R7 live bits", v, 32'h8001_0071);
        dma_req = 1'b0; fifo_service = 1'b0; port_busy = 1'b0;
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R6 clear all", v, 32'h8000_0000);

        // R9 version
        wr(8'h30, 32'h1234_5678);
        rd(8'h30, v); chk("R9 version", v, VER);
        rd(8'h38, v); chk("R9 version alias", v, VER);
        chk("R9 ctrl untouched", ctrl_word, 32'h0000_0011);

        // R10 unmapped
        rd(8'h20, v); chk("R10 data group", v, 32'h0);
        rd(8'h02, v); chk("R10 bad offset", v, 32'h0);
        wr(8'h0C, 32'hFFFF_FFFF);
        chk("R10 bad offset write", ctrl_word, 32'h0000_0011);
        wr(8'h40, 32'hFFFF_FFFF);
        chk("R10 bad group write", ctrl_word, 32'h0000_0011);

        // R11 deselected write
        step(1'b0, 1'b1, 8'h00, 32'hFFFF_FFFF, 1'b0, 1'b0);
        chk("R11 no select", ctrl_word, 32'h0000_0011);

        // R5 soft reset
        step(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 1'b1);
        wr(8'h04, 32'h8000_0000);
        chk("R5 srst image", ctrl_word, 32'h8000_0000);
        step(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, 1'b0);
        rd(8'h10, v); chk("R5 flags wiped", v, 32'h8000_0000);
        step(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 1'b0);
        rd(8'h10, v); chk("R5 events ignored", v, 32'h8000_0000);
        wr(8'h04, 32'h0000_0001);
        chk("R5 set blocked", ctrl_word, 32'h8000_0000);
        wr(8'h08, 32'h8000_0000);
        chk("R5 release", ctrl_word, 32'h0);
        wr(8'h00, 32'h8000_0003);
        chk("R5 load with srst", ctrl_word, 32'h8000_0000);
        wr(8'h08, 32'h8000_0000);

        // random mix, all requirements against the bench model
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic [3:0]  offs [5];
            offs[0] = 4'h0; offs[1] = 4'h4; offs[2] = 4'h8; offs[3] = 4'hC; offs[4] = 4'h2;
            a = {4'($urandom % 5), offs[$urandom % 5]};
            d = $urandom;
            if (($urandom % 8) != 0) d[31] = 1'b0;
            dma_req = 1'($urandom); fifo_service = 1'($urandom); port_busy = 1'($urandom);
            if (($urandom % 2) == 0) begin
                rd(a, v);
                chk("R2 R6 R7 R9 R10 random read", v, exp_rd(a));
            end else begin
                step(1'($urandom % 8 != 0), 1'b1, a, d,
                     1'($urandom % 6 == 0), 1'($urandom % 6 == 0));
                chk("R3 R4 R5 random ctrl", ctrl_word, m_ctrl);
                chk("R8 random irq", {31'd0, err_irq},
                    {31'd0, (m_uf | m_ov) & m_ctrl[25]});
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule